// File: doc/BRIEF.md
# Bit test and modify unit

This combinational datapath block picks one bit out of a 16-bit or 32-bit operand, returns the current value of that bit as a carry flag, and in the same pass returns a new operand in which that bit is kept, forced high, forced low or flipped. A 2-bit operation code chooses the modification. The bit position is counted upward from the least significant bit. It may come from an 8-bit immediate or from a full register value. Either way it is folded to the operand width before use.

The execution stage places the block between the operand read and the register write-back. The write-enable output tells the write-back path whether the destination needs rewriting. The remaining arithmetic flags have no defined value after these operations, so the block drives them to zero and marks them as not valid.

The block has no state, so the state-machine layout of the house style does not apply. It has no states and no transitions to name.

Top module: `bit_test_unit`

## Requirements
- R1: `cf_o` equals the bit of `opnd_i` at the effective position, counted from bit 0 (the least significant bit), for every operation code.
- R2: The effective position is `bitpos_i[3:0]` when `dword_i` is 0 and `bitpos_i[4:0]` when `dword_i` is 1. All higher bits of `bitpos_i` have no effect on any output.
- R3: Operation code 2'b00 (test only) gives `result_o == opnd_i`.
- R4: Operation code 2'b01 (test and set) gives a result whose selected bit is 1.
- R5: Operation code 2'b10 (test and reset) gives a result whose selected bit is 0.
- R6: Operation code 2'b11 (test and complement) gives a result whose selected bit is the inverse of the old bit.
- R7: Every result bit other than the selected one equals the matching operand bit. In word mode (`dword_i` = 0) this means bits 31:16 always pass through unchanged.
- R8: `wr_en_o` is 0 for operation code 2'b00 and 1 for the other three codes.
- R9: `aux_flags_vld_o` is always 0, marking the overflow, sign, zero, auxiliary-carry and parity flags as undefined. `aux_flags_o` is driven to 5'b00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand; in word mode only bits 15:0 form the operand |
| bitpos_i | input | 32 | Bit position, from an immediate (zero-extended) or a register |
| dword_i | input | 1 | 1 selects a 32-bit operand, 0 selects a 16-bit operand |
| op_i | input | 2 | 00 test, 01 set, 10 reset, 11 complement |
| result_o | output | 32 | Operand after modification |
| cf_o | output | 1 | Old value of the selected bit |
| wr_en_o | output | 1 | Destination must be written back |
| aux_flags_o | output | 5 | Undefined arithmetic flags, driven to zero |
| aux_flags_vld_o | output | 1 | Always 0: the auxiliary flags carry no meaning |

## Verification
The bench runs a fixed table of vectors and then a long stream of random operands, positions, sizes and codes.

- **Table.** It covers each operation code on a bit holding 0 and on a bit holding 1. This separates a real set, clear or flip from a result that merely matches the old value.
- **Position folding.** Positions with high bits set show whether the position is reduced to 4 or 5 bits according to size.
- **Word mode.** Word-mode cases with a nonzero upper half show whether bits 31:16 leak into the result.
- **Extreme positions.** Directed cases at position 0 and at the top bit of each size expose off-by-one errors in mask generation.

// File: rtl/bt_pkg.sv
package bt_pkg;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int POS_W  = $clog2(DATA_W);
    localparam int AUX_W  = 5;

    typedef enum logic [1:0] {
        BT_TEST  = 2'b00,
        BT_SET   = 2'b01,
        BT_CLR   = 2'b10,
        BT_FLIP  = 2'b11
    } bt_op_e;
endpackage

// File: rtl/bt_mask_gen.sv
module bt_mask_gen
    import bt_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int PW   = $clog2(W),
    parameter int HPW  = PW - 1
) (
    input  logic [PW-1:0] pos_i,
    input  logic          full_i,
    output logic [W-1:0]  mask_o
);
    logic [PW-1:0] eff_pos;

    // word mode folds the position to the lower half
    always_comb begin
        eff_pos = full_i ? pos_i : {1'b0, pos_i[HPW-1:0]};
    end

    for (genvar b = 0; b < W; b++) begin : g_mask
        assign mask_o[b] = (eff_pos == PW'(b));
    end

    always_comb begin
        if (!$isunknown({pos_i, full_i})) begin
            assert_mask_onehot_R2: assert ($countones(mask_o) == 1);
            assert_word_upper_R7: assert (full_i || (mask_o[W-1:W/2] == '0));
        end
    end
endmodule

// File: rtl/bt_apply.sv
module bt_apply
    import bt_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] opnd_i,
    input  logic [W-1:0] mask_i,
    input  bt_op_e       op_i,
    output logic [W-1:0] res_o,
    output logic         bit_o
);
    always_comb begin
        bit_o = |(opnd_i & mask_i);
        unique case (op_i)
            BT_TEST: res_o = opnd_i;
            BT_SET:  res_o = opnd_i | mask_i;
            BT_CLR:  res_o = opnd_i & ~mask_i;
            BT_FLIP: res_o = opnd_i ^ mask_i;
            default: res_o = opnd_i;
        endcase
    end

    always_comb begin
        if (!$isunknown({opnd_i, mask_i, op_i})) begin
            assert_others_kept_R7: assert (((res_o ^ opnd_i) & ~mask_i) == '0);
            assert_set_bit_R4: assert (op_i != BT_SET || ((res_o & mask_i) == mask_i));
            assert_clr_bit_R5: assert (op_i != BT_CLR || ((res_o & mask_i) == '0));
            assert_flip_bit_R6: assert (op_i != BT_FLIP || ((|(res_o & mask_i)) != bit_o));
        end
    end
endmodule

// File: rtl/bit_test_unit.sv
module bit_test_unit
    import bt_pkg::*;
(
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [DATA_W-1:0] bitpos_i,
    input  logic              dword_i,
    input  logic [1:0]        op_i,
    output logic [DATA_W-1:0] result_o,
    output logic              cf_o,
    output logic              wr_en_o,
    output logic [AUX_W-1:0]  aux_flags_o,
    output logic              aux_flags_vld_o
);
    logic [DATA_W-1:0] sel_mask;
    bt_op_e            op_q;
    logic              unused_pos_hi;

    assign unused_pos_hi = ^bitpos_i[DATA_W-1:POS_W];
    assign op_q          = bt_op_e'(op_i);

    bt_mask_gen #(.W(DATA_W)) u_mask (
        .pos_i  (bitpos_i[POS_W-1:0]),
        .full_i (dword_i),
        .mask_o (sel_mask)
    );

    bt_apply #(.W(DATA_W)) u_apply (
        .opnd_i (opnd_i),
        .mask_i (sel_mask),
        .op_i   (op_q),
        .res_o  (result_o),
        .bit_o  (cf_o)
    );

    always_comb begin
        wr_en_o         = (op_q != BT_TEST);
        aux_flags_o     = '0;
        aux_flags_vld_o = 1'b0;
    end

    always_comb begin
        if (!$isunknown({opnd_i, op_i})) begin
            assert_test_nochange_R3: assert (op_q != BT_TEST || result_o == opnd_i);
            assert_upper_pass_R7: assert (dword_i !== 1'b0
                || result_o[DATA_W-1:HALF_W] == opnd_i[DATA_W-1:HALF_W]);
        end
    end
endmodule

// File: tb/sim_bit_test_unit.sv
module sim_bit_test_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam int NRAND = 3000;

    localparam logic [31:0] T_OPND [NVEC] = '{32'h0000_0001, 32'h8000_0000, 32'h0000_0000,
        32'h1234_5678, 32'hFFFF_0000, 32'hABCD_8000, 32'h0000_00F0, 32'h5555_5555};
    localparam logic [31:0] T_POS  [NVEC] = '{32'd0, 32'd31, 32'd31, 32'd35,
        32'd20, 32'd15, 32'h0001_0007, 32'd16};
    localparam logic        T_DW   [NVEC] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [1:0]  T_OP   [NVEC] = '{2'b00, 2'b10, 2'b01, 2'b11, 2'b01, 2'b11, 2'b10, 2'b00};
    localparam logic [31:0] T_RES  [NVEC] = '{32'h0000_0001, 32'h0000_0000, 32'h8000_0000,
        32'h1234_5670, 32'hFFFF_0010, 32'hABCD_0000, 32'h0000_0070, 32'h5555_5555};
    localparam logic        T_CF   [NVEC] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] opnd_i = '0;
    logic [31:0] bitpos_i = '0;
    logic        dword_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] result_o;
    logic        cf_o, wr_en_o, aux_flags_vld_o;
    logic [4:0]  aux_flags_o;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bit_test_unit u0 (
        .opnd_i(opnd_i), .bitpos_i(bitpos_i), .dword_i(dword_i), .op_i(op_i),
        .result_o(result_o), .cf_o(cf_o), .wr_en_o(wr_en_o),
        .aux_flags_o(aux_flags_o), .aux_flags_vld_o(aux_flags_vld_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] p, input logic d, input logic [1:0] o);
        @(posedge clk);
        #1;
        opnd_i = a; bitpos_i = p; dword_i = d; op_i = o;
        @(negedge clk);
    endtask

    // reference model from the requirements
    task automatic check_model(input string tag);
        int pos;
        logic [31:0] exp;
        logic old;
        pos = dword_i ? int'(bitpos_i[4:0]) : int'(bitpos_i[3:0]);
        old = opnd_i[pos];
        exp = opnd_i;
        case (op_i)
            2'b01: exp[pos] = 1'b1;
            2'b10: exp[pos] = 1'b0;
            2'b11: exp[pos] = ~old;
            default: ;
        endcase
        chk({tag, " R1 cf"}, {31'd0, cf_o}, {31'd0, old});
        chk({tag, " R3-R7 result"}, result_o, exp);
        chk({tag, " R8 wr_en"}, {31'd0, wr_en_o}, {31'd0, op_i != 2'b00});
        chk({tag, " R9 aux"}, {26'd0, aux_flags_vld_o, aux_flags_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // initial state with zero inputs: R3, R8, R9
        chk("R3 idle result", result_o, 32'd0);
        chk("R8 idle wr_en", {31'd0, wr_en_o}, 32'd0);
        chk("R9 idle aux valid", {31'd0, aux_flags_vld_o}, 32'd0);

        // vector table: R1 R2 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            apply(T_OPND[i], T_POS[i], T_DW[i], T_OP[i]);
            chk("R1 table cf", {31'd0, cf_o}, {31'd0, T_CF[i]});
            chk("R2 R7 table result", result_o, T_RES[i]);
            chk("R8 table wr_en", {31'd0, wr_en_o}, {31'd0, T_OP[i] != 2'b00});
        end

        // corner cases: bit 0 and top bit of each size, all ops
        for (int o = 0; o < 4; o++) begin
            apply(32'hFFFF_FFFF, 32'd0, 1'b1, 2'(o));      check_model("corner dw bit0");
            apply(32'h7FFF_FFFF, 32'd31, 1'b1, 2'(o));     check_model("corner dw bit31");
            apply(32'hA5A5_0000, 32'd15, 1'b0, 2'(o));     check_model("corner w bit15");
            apply(32'h0000_FFFE, 32'hFFFF_FFE0, 1'b0, 2'(o)); check_model("corner w bit0 R2");
        end

        // R2: upper position bits ignored
        apply(32'h0000_0400, 32'd10, 1'b1, 2'b11);
        chk("R2 base", result_o, 32'h0);
        apply(32'h0000_0400, 32'hFFFF_FFEA, 1'b1, 2'b11);
        chk("R2 high bits ignored", result_o, 32'h0);

        for (int k = 0; k < NRAND; k++) begin
            apply($urandom, $urandom, 1'($urandom), 2'($urandom));
            check_model("random");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule